// File: doc/BRIEF.md
# Single-Error-Correcting Word Store

This block holds 16-bit words in a small register-modelled memory. Each stored word carries a 5-bit Hamming code. On a write, the block checks odd parity on the write address and on the incoming data, and flags any mismatch. It then encodes the word. Check bit A travels with the data as a seventeenth bit in the main array. Check bits B to E go to a narrower side array that shares the same address.

On a read, both arrays are read and the check bits are recomputed from the returned data. The difference between stored and recomputed check bits is the error code, which is registered together with the raw data. A zero code lets the data through untouched. A code equal to a data bit's position in the codeword inverts that one bit. A code that names a check-bit position leaves the data alone. The output parity bit is always formed from the word actually driven.

A fault-injection mask applied at write time lets any single codeword bit be corrupted on its way into storage.

Top module: `ecc_word_store`

## Requirements
- R1: A write with `^{wr_addr, wr_addr_par} == 0` (even overall, so odd parity is violated) raises `addr_par_err` for exactly the one cycle after the write edge. A write with correct odd address parity leaves it low.
- R2: A write with `^{wr_data, wr_data_par} == 0` raises `data_par_err` for exactly the one cycle after the write edge. Correct odd data parity leaves it low.
- R3: A read of a word stored without corruption gives `rd_valid` high for one cycle, starting one edge after `rd_en`. In that cycle `rd_data` equals the written word and `err_code` is 0.
- R4: Data bit i sits at the (i+1)-th codeword position in 1..21 that is not a power of two (bit 0 at 3, bit 15 at 21). When `flip_mask[i]` (i in 0..15) corrupts that bit at write time, the read returns the original word and `err_code` equals that position.
- R5: `flip_mask[16+k]` corrupts check bit k (A=0 .. E=4). The read then returns the stored data unchanged, with `err_code == 1<<k`.
- R6: Whenever `rd_valid` is high, `^{rd_data, rd_par} == 1`, so odd parity holds over the driven, corrected word.
- R7: `err_flag` is high exactly in a valid read cycle whose `err_code` is nonzero.
- R8: A read and a write in the same cycle at the same address return the contents from before that write. A later read returns the new word.
- R9: After reset, `rd_valid`, `err_flag`, `addr_par_err`, `data_par_err` and `rd_data` are all 0.
- R10: A write flagged with a parity error is still stored and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_addr_par | input | 1 | Odd parity bit for `wr_addr` |
| wr_data | input | DATA_W | Write data |
| wr_data_par | input | 1 | Odd parity bit for `wr_data` |
| flip_mask | input | DATA_W+CHK_W | Per-bit corruption of the stored codeword (data bits low, check bits A.. high) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| addr_par_err | output | 1 | Write address parity mismatch, one cycle |
| data_par_err | output | 1 | Write data parity mismatch, one cycle |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DATA_W | Corrected read data |
| rd_par | output | 1 | Odd parity over `rd_data` |
| err_code | output | CHK_W | Registered error code of the last read |
| err_flag | output | 1 | Nonzero error code in a valid read cycle |

## Verification
The write-side parity check and the read-side correction run in separate pipelines and can report in the same cycle. The bench provokes this by issuing a write with bad data parity to one address in the same cycle as a read of a word stored with a corrupted data bit. It then checks that `data_par_err`, `err_flag`, the error code and the corrected word all appear together and stay independent. It also issues a read and a write to the same address together, and judges that the read returns the old word and that the new word follows on the next read.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  // number of Hamming check bits needed to cover dw data bits
  function automatic int chk_bits(input int dw);
    int c;
    c = 1;
    while ((1 << c) < dw + c + 1) c++;
    return c;
  endfunction

  // codeword position (1-based) of data bit idx: the idx-th non-power-of-two
  function automatic int code_pos(input int idx);
    int n;
    int res;
    n = 0;
    res = 0;
    for (int p = 1; p < 128; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == idx) res = p;
        n++;
      end
    end
    return res;
  endfunction

  // data bits covered by check bit k
  function automatic logic [63:0] cover_mask(input int k, input int dw);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < dw; i++) begin
      if (((code_pos(i) >> k) & 1) != 0) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/ecc_check_gen.sv
module ecc_check_gen #(
  parameter int DW = 16,
  parameter int CW = 5
) (
  input  logic [DW-1:0] data,
  output logic [CW-1:0] chk
);
  for (genvar k = 0; k < CW; k++) begin : g_chk
    localparam logic [63:0] COVER = ecc_pkg::cover_mask(k, DW);
    assign chk[k] = ^(data & COVER[DW-1:0]);
  end
endmodule

// File: rtl/ecc_write_check.sv
module ecc_write_check #(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_addr_par,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_data_par,
  output logic [CW-1:0] chk,
  output logic          addr_par_err,
  output logic          data_par_err
);
  logic ap_err_d, dp_err_d;
  logic ap_err_q, dp_err_q;

  ecc_check_gen #(.DW(DW), .CW(CW)) u_gen (
    .data (wr_data),
    .chk  (chk)
  );

  always_comb begin
    ap_err_d = wr_en & ~(^{wr_addr, wr_addr_par});
    dp_err_d = wr_en & ~(^{wr_data, wr_data_par});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_err_q <= 1'b0;
      dp_err_q <= 1'b0;
    end else begin
      ap_err_q <= ap_err_d;
      dp_err_q <= dp_err_d;
    end
  end

  assign addr_par_err = ap_err_q;
  assign data_par_err = dp_err_q;
endmodule

// File: rtl/ecc_word_array.sv
module ecc_word_array #(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW:0]   wmain,
  input  logic [CW-2:0] wside,
  input  logic [AW-1:0] raddr,
  output logic [DW:0]   rmain,
  output logic [CW-2:0] rside
);
  localparam int DEPTH = 1 << AW;

  logic [DW:0]   main_mem [DEPTH];
  logic [CW-2:0] side_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      main_mem[waddr] <= wmain;
      side_mem[waddr] <= wside;
    end
  end

  assign rmain = main_mem[raddr];
  assign rside = side_mem[raddr];
endmodule

// File: rtl/ecc_read_correct.sv
module ecc_read_correct #(
  parameter int DW = 16,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [DW-1:0] raw_data,
  input  logic [CW-1:0] raw_chk,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_par,
  output logic [CW-1:0] err_code,
  output logic          err_flag
);
  logic [CW-1:0] regen;
  logic [CW-1:0] code_d, code_q;
  logic [DW-1:0] data_d, data_q;
  logic          valid_q;
  logic [DW-1:0] fixed;

  ecc_check_gen #(.DW(DW), .CW(CW)) u_regen (
    .data (raw_data),
    .chk  (regen)
  );

  always_comb begin
    data_d = data_q;
    code_d = code_q;
    if (rd_en) begin
      data_d = raw_data;
      code_d = regen ^ raw_chk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      code_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      code_q  <= code_d;
      valid_q <= rd_en;
    end
  end

  // invert the single data bit whose codeword position matches the code
  for (genvar i = 0; i < DW; i++) begin : g_fix
    localparam logic [CW-1:0] POS = CW'(ecc_pkg::code_pos(i));
    assign fixed[i] = data_q[i] ^ (code_q == POS);
  end

  assign rd_valid = valid_q;
  assign rd_data  = fixed;
  assign rd_par   = ~(^fixed);
  assign err_code = code_q;
  assign err_flag = valid_q & (|code_q);
endmodule

// File: rtl/ecc_word_store.sv
module ecc_word_store #(
  parameter  int DATA_W = 16,
  parameter  int ADDR_W = 4,
  localparam int CHK_W  = ecc_pkg::chk_bits(DATA_W),
  localparam int CWD_W  = DATA_W + CHK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_addr_par,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_data_par,
  input  logic [CWD_W-1:0]  flip_mask,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              addr_par_err,
  output logic              data_par_err,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_par,
  output logic [CHK_W-1:0]  err_code,
  output logic              err_flag
);
  logic [1:0]        rst_sync;
  logic              rst_i_n;
  logic [CHK_W-1:0]  wchk;
  logic [DATA_W:0]   wmain, rmain;
  logic [CHK_W-2:0]  wside, rside;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  ecc_write_check #(.DW(DATA_W), .AW(ADDR_W), .CW(CHK_W)) u_wchk (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_addr_par  (wr_addr_par),
    .wr_data      (wr_data),
    .wr_data_par  (wr_data_par),
    .chk          (wchk),
    .addr_par_err (addr_par_err),
    .data_par_err (data_par_err)
  );

  // check bit A rides as the extra main-array bit, the rest in the side array
  always_comb begin
    wmain = {wchk[0], wr_data} ^ {flip_mask[DATA_W], flip_mask[DATA_W-1:0]};
    wside = wchk[CHK_W-1:1] ^ flip_mask[CWD_W-1:DATA_W+1];
  end

  ecc_word_array #(.DW(DATA_W), .AW(ADDR_W), .CW(CHK_W)) u_arr (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wmain (wmain),
    .wside (wside),
    .raddr (rd_addr),
    .rmain (rmain),
    .rside (rside)
  );

  ecc_read_correct #(.DW(DATA_W), .CW(CHK_W)) u_rcor (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .rd_en    (rd_en),
    .raw_data (rmain[DATA_W-1:0]),
    .raw_chk  ({rside, rmain[DATA_W]}),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_par   (rd_par),
    .err_code (err_code),
    .err_flag (err_flag)
  );
endmodule

// File: rtl/ecc_word_store_chk.sv
module ecc_word_store_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int CHK_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_addr_par,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_data_par,
  input logic              rd_en,
  input logic              addr_par_err,
  input logic              data_par_err,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_par,
  input logic [CHK_W-1:0]  err_code,
  input logic              err_flag
);
  a_r1_addr_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(^{wr_addr, wr_addr_par})) |=> addr_par_err);
  a_r1_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !(^{wr_addr, wr_addr_par})) |=> !addr_par_err);
  a_r2_data_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(^{wr_data, wr_data_par})) |=> data_par_err);
  a_r2_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !(^{wr_data, wr_data_par})) |=> !data_par_err);
  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r3_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  a_r6_odd_out: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (^{rd_data, rd_par}));
  a_r7_flag_code: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> (rd_valid && err_code != '0));
  a_r7_flag_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && err_code != '0) |-> err_flag);
endmodule

bind ecc_word_store ecc_word_store_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .CHK_W  (CHK_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_i_n),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_addr_par  (wr_addr_par),
  .wr_data      (wr_data),
  .wr_data_par  (wr_data_par),
  .rd_en        (rd_en),
  .addr_par_err (addr_par_err),
  .data_par_err (data_par_err),
  .rd_valid     (rd_valid),
  .rd_data      (rd_data),
  .rd_par       (rd_par),
  .err_code     (err_code),
  .err_flag     (err_flag)
);

// File: tb/ecc_word_store_tb_top.sv
module ecc_word_store_tb_top;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int CW = 5;
  localparam int NV = 8;

  // {addr[40:37], data[36:21], flip_mask[20:0]}
  localparam logic [40:0] VEC [NV] = '{
    {4'd0,  16'h0000, 21'h000000},
    {4'd1,  16'hFFFF, 21'h000000},
    {4'd2,  16'hA5A5, 21'h000001},
    {4'd3,  16'h1234, 21'h008000},
    {4'd4,  16'h8001, 21'h000080},
    {4'd5,  16'h5A5A, 21'h010000},
    {4'd6,  16'h0F0F, 21'h100000},
    {4'd15, 16'hC3C3, 21'h000400}
  };

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          wr_addr_par;
  logic [DW-1:0] wr_data;
  logic          wr_data_par;
  logic [DW+CW-1:0] flip_mask;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic          addr_par_err, data_par_err, rd_valid, rd_par, err_flag;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] err_code;

  int checks;
  int failures;
  bit done;

  ecc_word_store #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_addr_par  (wr_addr_par),
    .wr_data      (wr_data),
    .wr_data_par  (wr_data_par),
    .flip_mask    (flip_mask),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .addr_par_err (addr_par_err),
    .data_par_err (data_par_err),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .rd_par       (rd_par),
    .err_code     (err_code),
    .err_flag     (err_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int bench_pos(input int idx);
    int n;
    int found;
    n = 0;
    found = 0;
    for (int p = 1; p < 64; p++) begin
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32) begin
        if (n == idx) found = p;
        n++;
      end
    end
    return found;
  endfunction

  function automatic logic [CW-1:0] exp_code(input logic [DW+CW-1:0] m);
    logic [CW-1:0] c;
    c = '0;
    for (int j = 0; j < DW; j++) if (m[j]) c = c ^ CW'(bench_pos(j));
    for (int k = 0; k < CW; k++) if (m[DW+k]) c = c ^ CW'(1 << k);
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [DW+CW-1:0] m, input bit bad_ap, input bit bad_dp);
    @(negedge clk);
    wr_en       = 1'b1;
    wr_addr     = a;
    wr_addr_par = (~^a) ^ bad_ap;
    wr_data     = d;
    wr_data_par = (~^d) ^ bad_dp;
    flip_mask   = m;
    @(negedge clk);
    wr_en     = 1'b0;
    flip_mask = '0;
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [40:0] v;
    checks = 0; failures = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; wr_addr_par = 1'b1; wr_data = '0; wr_data_par = 1'b1;
    flip_mask = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    check("R9 rd_valid", 32'(rd_valid), 0);
    check("R9 err_flag", 32'(err_flag), 0);
    check("R9 addr_par_err", 32'(addr_par_err), 0);
    check("R9 data_par_err", 32'(data_par_err), 0);
    check("R9 rd_data", 32'(rd_data), 0);

    // vector table: write all, then read back
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      do_write(v[40:37], v[36:21], v[20:0], 1'b0, 1'b0);
      check("R1 clean addr parity", 32'(addr_par_err), 0);
      check("R2 clean data parity", 32'(data_par_err), 0);
    end
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      do_read(v[40:37]);
      check("R3 rd_valid", 32'(rd_valid), 1);
      check("R3 R4 R5 rd_data", 32'(rd_data), 32'(v[36:21]));
      check("R3 R4 R5 err_code", 32'(err_code), 32'(exp_code(v[20:0])));
      check("R7 err_flag", 32'(err_flag), 32'(exp_code(v[20:0]) != '0));
      check("R6 odd parity", 32'(^{rd_data, rd_par}), 1);
    end
    @(negedge clk);
    check("R3 valid one cycle", 32'(rd_valid), 0);
    check("R7 flag drops", 32'(err_flag), 0);

    // R1 / R10: bad address parity, still stored
    do_write(4'd9, 16'hBEEF, '0, 1'b1, 1'b0);
    check("R1 addr_par_err", 32'(addr_par_err), 1);
    check("R2 no data flag", 32'(data_par_err), 0);
    @(negedge clk);
    check("R1 flag one cycle", 32'(addr_par_err), 0);
    do_read(4'd9);
    check("R10 stored despite addr error", 32'(rd_data), 32'h0000BEEF);

    // R2 / R10: bad data parity, still stored
    do_write(4'd10, 16'h00F1, '0, 1'b0, 1'b1);
    check("R2 data_par_err", 32'(data_par_err), 1);
    check("R1 no addr flag", 32'(addr_par_err), 0);
    @(negedge clk);
    check("R2 flag one cycle", 32'(data_par_err), 0);
    do_read(4'd10);
    check("R10 stored despite data error", 32'(rd_data), 32'h000000F1);

    // simultaneous: corrected read of addr 2 with bad-parity write to addr 11
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 4'd2;
    wr_en = 1'b1; wr_addr = 4'd11; wr_addr_par = ~^(4'd11);
    wr_data = 16'h0007; wr_data_par = ^(16'h0007);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R2 flag with read", 32'(data_par_err), 1);
    check("R4 corrected with write", 32'(rd_data), 32'h0000A5A5);
    check("R4 code bit0", 32'(err_code), 3);
    check("R7 flag with write", 32'(err_flag), 1);

    // R8: read and write same address in one cycle
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 4'd3;
    wr_en = 1'b1; wr_addr = 4'd3; wr_addr_par = ~^(4'd3);
    wr_data = 16'h7777; wr_data_par = ~^(16'h7777);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R8 old data", 32'(rd_data), 32'h00001234);
    check("R8 old code bit15", 32'(err_code), 21);
    do_read(4'd3);
    check("R8 new data", 32'(rd_data), 32'h00007777);
    check("R8 new code", 32'(err_code), 0);
    check("R6 parity new", 32'(rd_par), 32'(~^(16'h7777)));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule